// File: doc/BRIEF.md
# FDDI Receive Line-State Detector

This block watches the receive path of an FDDI physical layer. An upstream symbol aligner hands it one pair of 5-bit code groups per clock, together with a valid strobe. The block sorts each pair into one of four kinds: an Idle pair, a start-delimiter pair, a pair of data code groups, or anything else. It counts runs of consecutive Idle pairs. From these it decides whether the line is Unknown, Idle, Super Idle or Active.

The current line state is a registered 2-bit code. The block also drives a flag that stays high while the line is in either Idle state. Each time the line enters a new state, the block emits a one-cycle entry pulse, and a sticky status register downstream latches these pulses. Unknown is only declared when the line leaves a known state. A line that comes out of reset stays quietly in Unknown until it earns a known state.

Top module: `fddi_line_state_det`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `line_state` is 00 (Unknown), `idle_seen` is 0 and all four entry pulses are 0.
- R2: An Idle pair has both code groups equal to 11111. The second consecutive valid Idle pair moves the line to Idle (code 01) and pulses `enter_idle`. A single Idle pair leaves the state unchanged, including when the state is Active.
- R3: The eighth consecutive valid Idle pair moves the line to Super Idle (code 10) and pulses `enter_super`. `idle_seen` stays 1 throughout Idle and Super Idle.
- R4: A start-delimiter pair (first group 11000, second group 10001) moves the line to Active (code 11) from any state and pulses `enter_active` if the line was not already Active.
- R5: While Active, the line stays Active with no pulse on a start-delimiter pair or on a pair of valid data code groups. The valid data code groups are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100 and 11101.
- R6: From Active, Idle or Super Idle, a pair that is neither Idle, nor a start delimiter, nor (for Active only) a data pair moves the line to Unknown (code 00) and pulses `enter_unknown`. A reversed delimiter (10001 then 11000) counts as such a pair.
- R7: While Unknown, pairs that are not Idle and not a start delimiter leave the line in Unknown with no pulse.
- R8: The Idle run count clears on any valid non-Idle pair, so an interrupted run must start again. The count saturates, so a long run keeps Super Idle without further pulses.
- R9: A cycle with `pair_vld` low changes neither the state nor the Idle run, and it produces no pulse.
- R10: Entry pulses last one cycle, at most one is high at a time, and each appears in the same cycle that `line_state` takes the new code. That is one clock after the pair is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one symbol pair per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| pair_vld | input | 1 | Symbol pair on `sym_first`/`sym_second` is valid |
| sym_first | input | 5 | First code group of the pair |
| sym_second | input | 5 | Second code group of the pair |
| line_state | output | 2 | 00 Unknown, 01 Idle, 10 Super Idle, 11 Active |
| idle_seen | output | 1 | High while in Idle or Super Idle |
| enter_idle | output | 1 | One-cycle pulse on entry to Idle |
| enter_super | output | 1 | One-cycle pulse on entry to Super Idle |
| enter_active | output | 1 | One-cycle pulse on entry to Active |
| enter_unknown | output | 1 | One-cycle pulse on entry to Unknown |

## Verification
Several kinds of stimulus are used.
- Clean Idle runs separate the two-pair and eight-pair thresholds. They also show that saturation causes no repeated pulse.
- Idle runs broken by a data pair tell a counter that clears apart from one that only pauses. Idle runs split by an invalid-strobe gap show the reverse: a gap must not break the run.
- Delimiter, data and reversed-delimiter pairs are sent in Active, Idle and Unknown. This shows that the same pair holds the line in one state and drops it to Unknown in another.
- A single Idle pair sent while Active confirms that a lone Idle pair below the threshold leaves the state unchanged.

// File: rtl/lsd_pkg.sv
// Package: shared types and code-group constants for the line-state detector.
// Assumes 5-bit code groups arrive already aligned.
package lsd_pkg;

    localparam int SYM_W = 5;

    // Line-state code as seen at the top-level port.
    typedef enum logic [1:0] {
        LS_UNKNOWN = 2'b00,
        LS_IDLE    = 2'b01,
        LS_SUPER   = 2'b10,
        LS_ACTIVE  = 2'b11
    } lstate_t;

    // Classification of one incoming code-group pair.
    typedef enum logic [1:0] {
        PK_OTHER = 2'b00,
        PK_IDLE  = 2'b01,
        PK_SDEL  = 2'b10,
        PK_DATA  = 2'b11
    } pair_kind_t;

    localparam logic [SYM_W-1:0] CG_IDLE = 5'b11111;
    localparam logic [SYM_W-1:0] CG_J    = 5'b11000;
    localparam logic [SYM_W-1:0] CG_K    = 5'b10001;

    // True when the code group is one of the sixteen data encodings.
    function automatic logic is_data_group(input logic [SYM_W-1:0] cg);
        logic hit;
        case (cg)
            5'b11110, 5'b01001, 5'b10100, 5'b10101,
            5'b01010, 5'b01011, 5'b01110, 5'b01111,
            5'b10010, 5'b10011, 5'b10110, 5'b10111,
            5'b11010, 5'b11011, 5'b11100, 5'b11101: hit = 1'b1;
            default:                                hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/lsd_pair_class.sv
// Module: lsd_pair_class
// Purely combinational sorter that labels one code-group pair as Idle,
// start delimiter, data, or other. Assumes the first group is the one
// received earlier on the line. No state; the valid strobe is not used here.
module lsd_pair_class
    import lsd_pkg::*;
#(
    parameter int W = SYM_W
) (
    input  logic [W-1:0] grp_a,
    input  logic [W-1:0] grp_b,
    output pair_kind_t   kind
);

    logic a_data;
    logic b_data;
    logic both_idle;
    logic is_sdel;

    // Per-group decode of the data alphabet.
    always_comb begin
        a_data = is_data_group(grp_a);
        b_data = is_data_group(grp_b);
    end

    // Fixed-pattern matches for the two control pairs.
    always_comb begin
        both_idle = (grp_a == CG_IDLE) && (grp_b == CG_IDLE);
        is_sdel   = (grp_a == CG_J) && (grp_b == CG_K);
    end

    // Priority select: control pairs first, then data, else other.
    always_comb begin
        if (both_idle) begin
            kind = PK_IDLE;
        end else if (is_sdel) begin
            kind = PK_SDEL;
        end else if (a_data && b_data) begin
            kind = PK_DATA;
        end else begin
            kind = PK_OTHER;
        end
    end

endmodule

// File: rtl/lsd_idle_run.sv
// Module: lsd_idle_run
// Counts consecutive valid Idle pairs, saturating at RUN_MAX and clearing
// on any valid non-Idle pair. Invalid cycles leave the count alone.
// Also gives the count that will hold after this cycle, so the state
// logic can act on the same pair without an extra cycle of delay.
module lsd_idle_run
    import lsd_pkg::*;
#(
    parameter int RUN_MAX = 8,
    localparam int CNT_W  = $clog2(RUN_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pair_vld,
    input  pair_kind_t       kind,
    output logic [CNT_W-1:0] run_now,
    output logic [CNT_W-1:0] run_next
);

    localparam logic [CNT_W-1:0] RUN_TOP = CNT_W'(RUN_MAX);

    // Next-count rule: hold when invalid, clear on non-Idle, else step up to the top.
    always_comb begin
        if (!pair_vld) begin
            run_next = run_now;
        end else if (kind != PK_IDLE) begin
            run_next = '0;
        end else if (run_now == RUN_TOP) begin
            run_next = run_now;
        end else begin
            run_next = run_now + CNT_W'(1);
        end
    end

    // Run register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_now <= '0;
        end else begin
            run_now <= run_next;
        end
    end

    AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        run_now <= RUN_TOP);  // R8

    AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_vld && kind != PK_IDLE) |=> (run_now == '0));  // R8

    AST_RUN_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_vld |=> $stable(run_now));  // R9

endmodule

// File: rtl/lsd_state_core.sv
// Module: lsd_state_core
// Line-state machine and entry-pulse generator. It uses the pair kind and
// the Idle run count for the current pair, and registers the new state and
// the entry pulses together, so a pulse always lines up with its state code.
// Assumes IDLE_MIN <= SUPER_MIN <= the counter's saturation value.
module lsd_state_core
    import lsd_pkg::*;
#(
    parameter int IDLE_MIN  = 2,
    parameter int SUPER_MIN = 8,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pair_vld,
    input  pair_kind_t       kind,
    input  logic [CNT_W-1:0] run_next,
    output lstate_t          state,
    output logic             idle_seen,
    output logic             pls_idle,
    output logic             pls_super,
    output logic             pls_active,
    output logic             pls_unknown
);

    localparam logic [CNT_W-1:0] IDLE_TH  = CNT_W'(IDLE_MIN);
    localparam logic [CNT_W-1:0] SUPER_TH = CNT_W'(SUPER_MIN);

    lstate_t nxt;
    logic    known_now;

    // Known means Active, Idle or Super Idle; only these may fall to Unknown.
    always_comb begin
        known_now = (state != LS_UNKNOWN);
    end

    // Next-state selection from the pair kind, the run length and the present state.
    always_comb begin
        nxt = state;
        if (pair_vld) begin
            unique case (kind)
                PK_SDEL: nxt = LS_ACTIVE;
                PK_IDLE: begin
                    if (run_next >= SUPER_TH) begin
                        nxt = LS_SUPER;
                    end else if (run_next >= IDLE_TH) begin
                        nxt = LS_IDLE;
                    end else begin
                        nxt = state;
                    end
                end
                PK_DATA: begin
                    if (state == LS_ACTIVE) begin
                        nxt = LS_ACTIVE;
                    end else if (known_now) begin
                        nxt = LS_UNKNOWN;
                    end else begin
                        nxt = state;
                    end
                end
                default: begin
                    if (known_now) begin
                        nxt = LS_UNKNOWN;
                    end else begin
                        nxt = state;
                    end
                end
            endcase
        end
    end

    // State register and entry pulses, updated together on each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= LS_UNKNOWN;
            pls_idle    <= 1'b0;
            pls_super   <= 1'b0;
            pls_active  <= 1'b0;
            pls_unknown <= 1'b0;
        end else begin
            state       <= nxt;
            pls_idle    <= (nxt == LS_IDLE)    && (state != LS_IDLE) && (state != LS_SUPER);
            pls_super   <= (nxt == LS_SUPER)   && (state != LS_SUPER);
            pls_active  <= (nxt == LS_ACTIVE)  && (state != LS_ACTIVE);
            pls_unknown <= (nxt == LS_UNKNOWN) && (state != LS_UNKNOWN);
        end
    end

    // Idle flag covers both Idle states.
    always_comb begin
        idle_seen = (state == LS_IDLE) || (state == LS_SUPER);
    end

    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pls_idle, pls_super, pls_active, pls_unknown}));  // R10

    AST_GAP_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_vld |=> ($stable(state) && !pls_idle && !pls_super && !pls_active && !pls_unknown));  // R9

    AST_UNKNOWN_FROM_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_vld && kind == PK_OTHER && known_now) |=> (pls_unknown && state == LS_UNKNOWN));  // R6

    AST_ACTIVE_ON_SDEL: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_vld && kind == PK_SDEL) |=> (state == LS_ACTIVE));  // R4

    AST_UNKNOWN_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_vld && state == LS_UNKNOWN && (kind == PK_DATA || kind == PK_OTHER)) |=> (state == LS_UNKNOWN && !pls_unknown));  // R7

endmodule

// File: rtl/fddi_line_state_det.sv
// Module: fddi_line_state_det
// Top level of the receive line-state detector. Wires the pair classifier,
// the Idle run counter and the state machine. Assumes one aligned pair per
// clock when pair_vld is high; the outputs are registered.
module fddi_line_state_det
    import lsd_pkg::*;
#(
    parameter int IDLE_MIN  = 2,
    parameter int SUPER_MIN = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pair_vld,
    input  logic [4:0] sym_first,
    input  logic [4:0] sym_second,
    output logic [1:0] line_state,
    output logic       idle_seen,
    output logic       enter_idle,
    output logic       enter_super,
    output logic       enter_active,
    output logic       enter_unknown
);

    localparam int CNT_W = $clog2(SUPER_MIN + 1);

    pair_kind_t       kind;
    logic [CNT_W-1:0] run_now;
    logic [CNT_W-1:0] run_next;
    lstate_t          state;

    lsd_pair_class #(.W(SYM_W)) u_class (
        .grp_a (sym_first),
        .grp_b (sym_second),
        .kind  (kind)
    );

    lsd_idle_run #(.RUN_MAX(SUPER_MIN)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .pair_vld (pair_vld),
        .kind     (kind),
        .run_now  (run_now),
        .run_next (run_next)
    );

    lsd_state_core #(
        .IDLE_MIN  (IDLE_MIN),
        .SUPER_MIN (SUPER_MIN),
        .CNT_W     (CNT_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .pair_vld    (pair_vld),
        .kind        (kind),
        .run_next    (run_next),
        .state       (state),
        .idle_seen   (idle_seen),
        .pls_idle    (enter_idle),
        .pls_super   (enter_super),
        .pls_active  (enter_active),
        .pls_unknown (enter_unknown)
    );

    // Export the state enum as a plain port code.
    always_comb begin
        line_state = state;
    end

    AST_SUPER_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LS_SUPER) |-> (run_now >= CNT_W'(SUPER_MIN)));  // R3

    AST_IDLE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LS_IDLE) |-> (run_now >= CNT_W'(IDLE_MIN)));  // R2

endmodule

// File: tb/tb_fddi_line_state_det.sv
// Scoreboard bench: the step task drives one cycle and queues the expected
// result; the monitor pops one entry per clock and compares it one time unit
// after the edge.
module tb_fddi_line_state_det;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pair_vld = 1'b0;
    logic [4:0] sym_first = '0;
    logic [4:0] sym_second = '0;
    logic [1:0] line_state;
    logic       idle_seen;
    logic       enter_idle;
    logic       enter_super;
    logic       enter_active;
    logic       enter_unknown;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [4:0] I_ = 5'b11111;
    localparam logic [4:0] J_ = 5'b11000;
    localparam logic [4:0] K_ = 5'b10001;
    localparam logic [4:0] D0 = 5'b11110;
    localparam logic [4:0] D5 = 5'b01011;
    localparam logic [4:0] BAD = 5'b00000;
    // pulse vector order: {unknown, active, super, idle}
    localparam logic [3:0] P_NONE = 4'b0000;
    localparam logic [3:0] P_IDLE = 4'b0001;
    localparam logic [3:0] P_SUP  = 4'b0010;
    localparam logic [3:0] P_ACT  = 4'b0100;
    localparam logic [3:0] P_UNK  = 4'b1000;

    logic [5:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    fddi_line_state_det dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pair_vld      (pair_vld),
        .sym_first     (sym_first),
        .sym_second    (sym_second),
        .line_state    (line_state),
        .idle_seen     (idle_seen),
        .enter_idle    (enter_idle),
        .enter_super   (enter_super),
        .enter_active  (enter_active),
        .enter_unknown (enter_unknown)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [4:0] a, input logic [4:0] b,
                        input logic [1:0] st, input logic [3:0] pl, input string tag);
        @(negedge clk);
        pair_vld   = v;
        sym_first  = a;
        sym_second = b;
        exp_q.push_back({st, pl});
        tag_q.push_back(tag);
    endtask

    // Monitor: one expected entry per driven cycle, compared after the edge.
    always @(posedge clk) begin
        if (exp_q.size() > 0) begin
            logic [5:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            #1;
            check(t, "line_state", int'(line_state), int'(e[5:4]));
            check(t, "pulses", int'({enter_unknown, enter_active, enter_super, enter_idle}), int'(e[3:0]));
            check(t, "idle_seen", int'(idle_seen), int'(e[5:4] == 2'b01 || e[5:4] == 2'b10));
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "line_state", int'(line_state), 0);
        check("R1", "idle_seen", int'(idle_seen), 0);
        check("R1", "pulses", int'({enter_unknown, enter_active, enter_super, enter_idle}), 0);
        rst_n = 1'b1;

        // R2: one Idle pair is not enough, the second enters Idle
        step(1, I_, I_, 2'b00, P_NONE, "R2");
        step(1, I_, I_, 2'b01, P_IDLE, "R2");
        // R3: runs 3..7 hold Idle, run 8 enters Super Idle
        for (int n = 3; n < 8; n++) step(1, I_, I_, 2'b01, P_NONE, "R3");
        step(1, I_, I_, 2'b10, P_SUP, "R3");
        // R8: saturated run keeps Super Idle with no pulse
        step(1, I_, I_, 2'b10, P_NONE, "R8");
        step(1, I_, I_, 2'b10, P_NONE, "R8");
        // R4: delimiter from Super Idle
        step(1, J_, K_, 2'b11, P_ACT, "R4");
        // R5: data and delimiter keep Active
        step(1, D0, D5, 2'b11, P_NONE, "R5");
        step(1, J_, K_, 2'b11, P_NONE, "R5");
        // R9: invalid cycle changes nothing
        step(0, BAD, BAD, 2'b11, P_NONE, "R9");
        // R6: invalid group in Active
        step(1, D0, BAD, 2'b00, P_UNK, "R6");
        // R7: Unknown holds on data and invalid pairs
        step(1, D0, D5, 2'b00, P_NONE, "R7");
        step(1, BAD, BAD, 2'b00, P_NONE, "R7");
        // R8: interrupted run restarts
        step(1, I_, I_, 2'b00, P_NONE, "R8");
        step(1, D0, D0, 2'b00, P_NONE, "R8");
        step(1, I_, I_, 2'b00, P_NONE, "R8");
        step(1, I_, I_, 2'b01, P_IDLE, "R8");
        // R6: data pair from Idle drops to Unknown
        step(1, D5, D0, 2'b00, P_UNK, "R6");
        // R9: gap does not break the run
        step(1, I_, I_, 2'b00, P_NONE, "R9");
        step(0, D0, D0, 2'b00, P_NONE, "R9");
        step(1, I_, I_, 2'b01, P_IDLE, "R9");
        // R4: delimiter from Idle
        step(1, J_, K_, 2'b11, P_ACT, "R4");
        // R2: single Idle pair holds Active, second enters Idle
        step(1, I_, I_, 2'b11, P_NONE, "R2");
        step(1, I_, I_, 2'b01, P_IDLE, "R2");
        // R6: J J pair from Idle
        step(1, J_, J_, 2'b00, P_UNK, "R6");
        // R10: delimiter from Unknown, then reversed delimiter
        step(1, J_, K_, 2'b11, P_ACT, "R10");
        step(1, K_, J_, 2'b00, P_UNK, "R6");
        step(0, I_, I_, 2'b00, P_NONE, "R9");

        @(negedge clk);
        pair_vld = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule